// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code, the operand bytes of an instruction, the two 8-bit index registers and the address of the next instruction into a 16-bit effective address. Modes that need no memory lookup (page-zero, absolute, their indexed forms, and relative branch targets) finish one clock after `start`. The three pointer modes run a short sequencer that reads a little-endian 16-bit pointer through a read port, one byte per cycle. The memory answers one clock after each request.

A decoder elsewhere supplies the mode code. This block reports the operand length of that code on `opLen` at all times, without a clock. The block accepts a new request only while it is idle. The result stays on `effAddr` until the next request completes, and `done` pulses for one cycle when the result updates.

Mode codes on `mode`: 0 implied, 1 accumulator, 2 immediate, 3 page-zero, 4 page-zero+X, 5 page-zero+Y, 6 relative, 7 absolute, 8 absolute+X, 9 absolute+Y, 10 indirect, 11 pre-indexed indirect (X), 12 post-indexed indirect (Y). Codes 13 to 15 are reserved.

Top module: `eaddr_gen`

## Requirements
- R1: `opLen` is 2 for codes 7, 8, 9 and 10. It is 1 for codes 2, 3, 4, 5, 6, 11 and 12. It is 0 for codes 0, 1 and 13 to 15.
- R2: In page-zero mode (code 3), `effAddr` becomes {0x00, operand[7:0]}, with `done` high in the cycle after the `start` edge.
- R3: The page-zero indexed modes (codes 4 and 5) give {0x00, (operand[7:0] + X or Y) mod 256}, so the result never leaves page zero.
- R4: Absolute mode (code 7) passes the 16-bit operand through. Codes 8 and 9 add X or Y to it modulo 65536. All three give `done` one cycle after `start`.
- R5: In relative mode (code 6), a taken branch gives `pc` plus the sign-extended operand[7:0], and an untaken branch gives `pc`. `pc` is the address of the next instruction.
- R6: Indirect mode (code 10) reads at operand and then at operand+1 (16-bit carry), on two consecutive cycles. The result is {second byte, first byte}, with `done` four cycles after `start`.
- R7: Pre-indexed mode (code 11) reads the pointer from page-zero address p = (operand[7:0]+X) mod 256 and from (p+1) mod 256. The pointer itself is the result.
- R8: Post-indexed mode (code 12) reads the pointer from operand[7:0] and from (operand[7:0]+1) mod 256. The result is that pointer plus Y, modulo 65536.
- R9: Codes 0, 1, 2 and 13 to 15 make no memory read. They give `effAddr` = 0x0000 with `done` one cycle after `start`.
- R10: `start` while a pointer sequence is running is ignored. The running result is not disturbed and no extra `done` follows.
- R11: After reset, `done` and `memRd` are 0 and `effAddr` is 0x0000.
- R12: `memRd` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; sampled only while idle |
| mode | input | 4 | Addressing-mode code |
| operand | input | 16 | Operand bytes, low byte in [7:0] |
| xIdx | input | 8 | X index register |
| yIdx | input | 8 | Y index register |
| pc | input | 16 | Address of the next instruction |
| branchTaken | input | 1 | Branch condition result for relative mode |
| memData | input | 8 | Read data, valid the cycle after `memRd` |
| memRd | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| effAddr | output | 16 | Effective address result |
| done | output | 1 | One-cycle pulse when `effAddr` updates |
| opLen | output | 2 | Operand length in bytes for `mode` |

## Verification
A sequencer stuck in a wrong state shows up within a cycle or two. `memRd` either goes high for a third cycle or starts while `done` is high, or `done` arrives at a latency other than one or four. A wrong captured operand or index shows up in the read addresses, in the cycle after `start`. A wrong captured low pointer byte shows up only in `effAddr` at the `done` pulse. Wrap errors appear only with operands near 0xFF or 0xFFFF, so the directed cases put the sums right at those edges.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int AW = 16;
  localparam int BW = 8;
  localparam int MW = 4;
  localparam int LW = 2;

  localparam logic [MW-1:0] AM_NONE  = 4'd0;
  localparam logic [MW-1:0] AM_ACC   = 4'd1;
  localparam logic [MW-1:0] AM_IMM   = 4'd2;
  localparam logic [MW-1:0] AM_ZP    = 4'd3;
  localparam logic [MW-1:0] AM_ZPX   = 4'd4;
  localparam logic [MW-1:0] AM_ZPY   = 4'd5;
  localparam logic [MW-1:0] AM_REL   = 4'd6;
  localparam logic [MW-1:0] AM_ABS   = 4'd7;
  localparam logic [MW-1:0] AM_ABSX  = 4'd8;
  localparam logic [MW-1:0] AM_ABSY  = 4'd9;
  localparam logic [MW-1:0] AM_IND   = 4'd10;
  localparam logic [MW-1:0] AM_PREX  = 4'd11;
  localparam logic [MW-1:0] AM_POSTY = 4'd12;

  typedef struct packed {
    logic finDirect;
    logic loadIn;
    logic rdLo;
    logic rdHi;
    logic capLo;
    logic finPtr;
  } eagStrobe_t;

  function automatic logic isPtrMode(input logic [MW-1:0] m);
    return (m == AM_IND) || (m == AM_PREX) || (m == AM_POSTY);
  endfunction

  function automatic logic [LW-1:0] lenOf(input logic [MW-1:0] m);
    logic [LW-1:0] r;
    case (m)
      AM_ABS, AM_ABSX, AM_ABSY, AM_IND: r = 2'd2;
      AM_IMM, AM_ZP, AM_ZPX, AM_ZPY, AM_REL, AM_PREX, AM_POSTY: r = 2'd1;
      default: r = 2'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] mode,
  output eagStrobe_t    strb
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_LAND} eagState_e;

  eagState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (isPtrMode(mode)) begin
            strb.loadIn = 1'b1;
            nextState   = S_LO;
          end else begin
            strb.finDirect = 1'b1;
          end
        end
      end
      S_LO: begin
        strb.rdLo = 1'b1;
        nextState = S_HI;
      end
      S_HI: begin
        strb.rdHi  = 1'b1;
        strb.capLo = 1'b1;
        nextState  = S_LAND;
      end
      S_LAND: begin
        strb.finPtr = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  eagStrobe_t    strb,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] operand,
  input  logic [BW-1:0] xIdx,
  input  logic [BW-1:0] yIdx,
  input  logic [AW-1:0] pc,
  input  logic          branchTaken,
  input  logic [BW-1:0] memData,
  output logic          memRd,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] effAddr,
  output logic          done,
  output logic [LW-1:0] opLen
);
  localparam int HW = AW - BW;

  logic [MW-1:0] modeQ;
  logic [AW-1:0] operandQ;
  logic [BW-1:0] xQ, yQ, loQ;
  logic [AW-1:0] directAddr, ptrLoAddr, ptrHiAddr, ptrResult;
  logic [BW-1:0] zpBase;

  assign opLen = lenOf(mode);

  // direct modes, computed from the live inputs
  always_comb begin
    case (mode)
      AM_ZP:   directAddr = {{HW{1'b0}}, operand[BW-1:0]};
      AM_ZPX:  directAddr = {{HW{1'b0}}, BW'(operand[BW-1:0] + xIdx)};
      AM_ZPY:  directAddr = {{HW{1'b0}}, BW'(operand[BW-1:0] + yIdx)};
      AM_ABS:  directAddr = operand;
      AM_ABSX: directAddr = operand + {{HW{1'b0}}, xIdx};
      AM_ABSY: directAddr = operand + {{HW{1'b0}}, yIdx};
      AM_REL:  directAddr = branchTaken
                 ? pc + {{HW{operand[BW-1]}}, operand[BW-1:0]}
                 : pc;
      default: directAddr = '0;
    endcase
  end

  // pointer location, computed from the captured request
  always_comb begin
    zpBase = (modeQ == AM_PREX) ? BW'(operandQ[BW-1:0] + xQ) : operandQ[BW-1:0];
    if (modeQ == AM_IND) begin
      ptrLoAddr = operandQ;
      ptrHiAddr = operandQ + AW'(1);
    end else begin
      ptrLoAddr = {{HW{1'b0}}, zpBase};
      ptrHiAddr = {{HW{1'b0}}, BW'(zpBase + BW'(1))};
    end
  end

  always_comb begin
    ptrResult = {memData, loQ};
    if (modeQ == AM_POSTY) ptrResult = {memData, loQ} + {{HW{1'b0}}, yQ};
  end

  assign memRd   = strb.rdLo | strb.rdHi;
  assign memAddr = strb.rdLo ? ptrLoAddr : (strb.rdHi ? ptrHiAddr : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= AM_NONE;
      operandQ <= '0;
      xQ       <= '0;
      yQ       <= '0;
      loQ      <= '0;
    end else begin
      if (strb.loadIn) begin
        modeQ    <= mode;
        operandQ <= operand;
        xQ       <= xIdx;
        yQ       <= yIdx;
      end
      if (strb.capLo) loQ <= memData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.finDirect | strb.finPtr;
      if (strb.finDirect)   effAddr <= directAddr;
      else if (strb.finPtr) effAddr <= ptrResult;
    end
  end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eag_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] operand,
  input  logic [BW-1:0] xIdx,
  input  logic [BW-1:0] yIdx,
  input  logic [AW-1:0] pc,
  input  logic          branchTaken,
  input  logic [BW-1:0] memData,
  output logic          memRd,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] effAddr,
  output logic          done,
  output logic [LW-1:0] opLen
);
  eagStrobe_t strb;

  eag_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .strb  (strb)
  );

  eag_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .mode        (mode),
    .operand     (operand),
    .xIdx        (xIdx),
    .yIdx        (yIdx),
    .pc          (pc),
    .branchTaken (branchTaken),
    .memData     (memData),
    .memRd       (memRd),
    .memAddr     (memAddr),
    .effAddr     (effAddr),
    .done        (done),
    .opLen       (opLen)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk
  import eag_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic [MW-1:0] mode,
  input logic          memRd,
  input logic [AW-1:0] memAddr,
  input logic          done,
  input logic [LW-1:0] opLen
);
  // R6
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |=> memRd);

  // R6
  rd_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |=> !memRd);

  // R6
  rd_next_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr[BW-1:0] == BW'($past(memAddr[BW-1:0]) + BW'(1))));

  // R12
  rd_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !done);

  // R1
  len_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode >= AM_ABS && mode <= AM_IND) |-> (opLen == 2'd2));

  // R1
  len_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode < AM_IMM || mode > AM_POSTY) |-> (opLen == 2'd0));
endmodule

bind eaddr_gen eag_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mode    (mode),
  .memRd   (memRd),
  .memAddr (memAddr),
  .done    (done),
  .opLen   (opLen)
);

// File: tb/sim_eaddr_gen.sv
`timescale 1ns/1ps
module sim_eaddr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] operand = 16'd0;
  logic [7:0]  xIdx = 8'd0, yIdx = 8'd0;
  logic [15:0] pc = 16'd0;
  logic        branchTaken = 1'b0;
  logic [7:0]  memData = 8'd0;
  logic        memRd;
  logic [15:0] memAddr, effAddr;
  logic        done;
  logic [1:0]  opLen;

  int total = 0;
  int bad = 0;
  int rdCount = 0;
  logic [15:0] rdLog [0:3];

  always #10 clk = ~clk;

  eaddr_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .operand(operand),
    .xIdx(xIdx), .yIdx(yIdx), .pc(pc), .branchTaken(branchTaken),
    .memData(memData), .memRd(memRd), .memAddr(memAddr), .effAddr(effAddr),
    .done(done), .opLen(opLen)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd7 + a[15:8] * 8'd3 + 8'h11;
    return r;
  endfunction

  always @(posedge clk) if (memRd) memData <= memByte(memAddr);

  always @(negedge clk) if (memRd) begin
    if (rdCount < 4) rdLog[rdCount] = memAddr;
    rdCount = rdCount + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [3:0] m, input logic [15:0] op,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                       input logic tk, input logic [15:0] expAddr, input int expLat,
                       input logic [15:0] rd0, input logic [15:0] rd1);
    int lat;
    @(negedge clk);
    mode = m; operand = op; xIdx = x; yIdx = y; pc = p; branchTaken = tk;
    start = 1'b1; rdCount = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check({req, " latency"}, lat, expLat);
    check({req, " effAddr"}, effAddr, expAddr);
    check({req, " reads"}, rdCount, (expLat == 4) ? 2 : 0);
    if (expLat == 4 && rdCount == 2) begin
      check({req, " lo addr"}, rdLog[0], rd0);
      check({req, " hi addr"}, rdLog[1], rd1);
    end
    @(negedge clk);
    check({req, " done pulse"}, done, 1'b0);
  endtask

  task automatic testReset();
    check("R11 done", done, 1'b0);
    check("R11 memRd", memRd, 1'b0);
    check("R11 effAddr", effAddr, 16'h0000);
  endtask

  task automatic testLengths();
    for (int m = 0; m < 16; m++) begin
      logic [1:0] e;
      if (m >= 7 && m <= 10) e = 2'd2;
      else if (m >= 2 && m <= 12) e = 2'd1;
      else e = 2'd0;
      mode = 4'(m);
      #1;
      check("R1 opLen", opLen, e);
    end
  endtask

  task automatic testPageZero();
    runOp("R2 zp", 4'd3, 16'hAB42, 8'h10, 8'h20, 16'h0, 1'b0, 16'h0042, 1, 0, 0);
    runOp("R3 zpx wrap", 4'd4, 16'h00F0, 8'h20, 8'h00, 16'h0, 1'b0, 16'h0010, 1, 0, 0);
    runOp("R3 zpy", 4'd5, 16'h0080, 8'h00, 8'h90, 16'h0, 1'b0, 16'h0010, 1, 0, 0);
  endtask

  task automatic testAbsolute();
    runOp("R4 abs", 4'd7, 16'hBEEF, 8'h11, 8'h22, 16'h0, 1'b0, 16'hBEEF, 1, 0, 0);
    runOp("R4 absx carry", 4'd8, 16'h12F0, 8'h20, 8'h00, 16'h0, 1'b0, 16'h1310, 1, 0, 0);
    runOp("R4 absy wrap", 4'd9, 16'hFFF0, 8'h00, 8'h30, 16'h0, 1'b0, 16'h0020, 1, 0, 0);
  endtask

  task automatic testRelative();
    runOp("R5 back", 4'd6, 16'h0080, 8'h0, 8'h0, 16'h1000, 1'b1, 16'h0F80, 1, 0, 0);
    runOp("R5 fwd", 4'd6, 16'h007F, 8'h0, 8'h0, 16'h1000, 1'b1, 16'h107F, 1, 0, 0);
    runOp("R5 untaken", 4'd6, 16'h0080, 8'h0, 8'h0, 16'h1000, 1'b0, 16'h1000, 1, 0, 0);
  endtask

  task automatic testPointers();
    runOp("R6 ind", 4'd10, 16'h30FF, 8'h5, 8'h6, 16'h0, 1'b0,
          {memByte(16'h3100), memByte(16'h30FF)}, 4, 16'h30FF, 16'h3100);
    runOp("R7 prex wrap", 4'd11, 16'h00F8, 8'h07, 8'h33, 16'h0, 1'b0,
          {memByte(16'h0000), memByte(16'h00FF)}, 4, 16'h00FF, 16'h0000);
    runOp("R8 posty", 4'd12, 16'h00FF, 8'h44, 8'hFF, 16'h0, 1'b0,
          {memByte(16'h0000), memByte(16'h00FF)} + 16'h00FF, 4, 16'h00FF, 16'h0000);
    runOp("R8 posty plain", 4'd12, 16'h0040, 8'h00, 8'h10, 16'h0, 1'b0,
          {memByte(16'h0041), memByte(16'h0040)} + 16'h0010, 4, 16'h0040, 16'h0041);
  endtask

  task automatic testNoMemory();
    runOp("R9 imm", 4'd2, 16'h1234, 8'h1, 8'h1, 16'h4000, 1'b1, 16'h0000, 1, 0, 0);
    runOp("R9 reserved", 4'd14, 16'h5678, 8'h1, 8'h1, 16'h4000, 1'b1, 16'h0000, 1, 0, 0);
  endtask

  task automatic testBusyStart();
    int lat;
    int extra;
    logic [15:0] exp;
    exp = {memByte(16'h2001), memByte(16'h2000)};
    @(negedge clk);
    mode = 4'd10; operand = 16'h2000; start = 1'b1; rdCount = 0;
    @(negedge clk);
    mode = 4'd3; operand = 16'h0055;
    lat = 1;
    @(negedge clk); lat++;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check("R10 latency", lat, 4);
    check("R10 effAddr", effAddr, exp);
    check("R10 reads", rdCount, 2);
    extra = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R10 no extra done", extra, 0);
    check("R10 effAddr held", effAddr, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLengths();
    testPageZero();
    testAbsolute();
    testRelative();
    testPointers();
    testNoMemory();
    testBusyStart();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule